// File: doc/BRIEF.md
# Loadable Turing Machine Step Engine

This block executes a single-tape Turing machine held entirely on chip. A 64-cell tape of 2-bit symbols, a head pointer and a 4-bit control state are kept in registers. Next to them sits an action table with one entry for every pair of control state and scanned symbol. Each entry holds a next state, a symbol to write, a head move and a valid flag. While the engine is idle, the table, the tape cells and the head position are loaded through simple write ports. A one-cycle start pulse then launches execution, and the engine applies exactly one transition on each clock until it reaches a stopping state.

Within a step the symbol from the table is written into the scanned cell first, then the head is moved, and then the control state is replaced. Two state codes are reserved: one means the machine halted normally, the other means error. The engine stops when it enters either of them. It also enters the error state when the table has no valid entry for the current pair, or when a move would take the head past either end of the tape. A saturating counter records how many transitions were applied. A combinational read port lets the surrounding logic inspect any tape cell.

Top module: `tm_engine`

## Requirements
- R1: After reset the engine is idle (running=0) with control state 0 (the starting state), head at cell 32 and step_count 0. Every tape cell holds the blank code 0, and every action table entry is invalid.
- R2: A start pulse seen while idle sets running=1 at that clock edge, loads control state 0 and clears step_count. A start pulse seen while running has no effect.
- R3: While running, each clock edge applies the table entry indexed by {cur_state, scanned symbol}. It writes the entry's symbol into the scanned cell, then moves the head by the move code (1 = cell index minus one, 2 = cell index plus one, 0 and 3 = stay), then loads the entry's next state.
- R4: A transition whose next state is 14 (halt) ends execution at that edge: running=0, halted=1, error=0.
- R5: If the entry for the current pair has its valid flag clear, the engine goes to state 15 (error) with running=0. The tape, head and step_count are left unchanged.
- R6: A valid entry whose next state is 15 is applied in full (write and move), and then error=1 with running=0.
- R7: If a move would take the head below cell 0 or above cell 63, the symbol is still written and the step is counted. The head stays where it is, and the state becomes 15 with running=0.
- R8: step_count increases by one for each applied valid entry and saturates at 65535.
- R9: Table writes (tbl_we), tape writes (tape_we) and head loads (head_we) take effect at the clock edge only while running=0. While running they are ignored.
- R10: rd_data always equals the tape cell at rd_addr, with no clock delay.
- R11: A 3-state busy beaver table applied to a blank tape from head 32 halts after 13 steps. At that point cells 30 to 35 hold symbol 1, cells 29 and 36 are blank, and the head is at 31, over the second of the six 1s. The table, with states 0, 1, 2 and symbol 1, is: (0,blank)->write 1, move 1, state 1. (0,1)->write 1, move 2, state 2. (1,blank)->write 1, move 2, state 0. (1,1)->write 1, move 1, state 1. (2,blank)->write 1, move 2, state 1. (2,1)->write 1, move 1, state 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution from the starting state |
| tbl_we | input | 1 | Action table write strobe |
| tbl_state | input | 4 | Table entry index: control state |
| tbl_sym | input | 2 | Table entry index: scanned symbol |
| tbl_next | input | 4 | Entry field: next control state |
| tbl_wsym | input | 2 | Entry field: symbol to write |
| tbl_move | input | 2 | Entry field: head move code |
| tbl_valid | input | 1 | Entry field: entry is defined |
| tape_we | input | 1 | Tape preload write strobe |
| tape_addr | input | 6 | Tape preload cell index |
| tape_wdata | input | 2 | Tape preload symbol |
| head_we | input | 1 | Head position load strobe |
| head_wdata | input | 6 | Head position to load |
| rd_addr | input | 6 | Inspection port cell index |
| rd_data | output | 2 | Inspection port symbol |
| running | output | 1 | Engine is executing transitions |
| halted | output | 1 | Control state is the halt code |
| error | output | 1 | Control state is the error code |
| step_count | output | 16 | Saturating count of applied transitions |
| cur_state | output | 4 | Current control state |
| head_pos | output | 6 | Current head cell index |

## Verification
Every registered result (running, cur_state, head_pos, step_count, the flags and the tape contents) changes at the same clock edge that samples the stimulus or applies the transition. The bench therefore compares them a quarter period after each rising edge against a behavioural model that updates on that same edge. The inspection port has no clock delay. A new rd_addr is driven after each comparison and rd_data is checked one time unit later, which sweeps the whole tape over the course of the run. Stop conditions, the ignored loads during execution and counter saturation are all judged at the first edge where they take effect.

// File: rtl/tm_pkg.sv
package tm_pkg;
   // Head move codes; 3 behaves like stay.
   typedef enum logic [1:0] {
      MV_STAY = 2'd0,
      MV_DEC  = 2'd1,
      MV_INC  = 2'd2,
      MV_HOLD = 2'd3
   } move_e;
endpackage

// File: rtl/tm_action_table.sv
module tm_action_table
   import tm_pkg::*;
#(
   parameter int ST_W  = 4,
   parameter int SYM_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [ST_W-1:0]  wr_state,
   input  logic [SYM_W-1:0] wr_sym,
   input  logic [ST_W-1:0]  wr_next,
   input  logic [SYM_W-1:0] wr_wsym,
   input  move_e            wr_move,
   input  logic             wr_valid,
   input  logic [ST_W-1:0]  rd_state,
   input  logic [SYM_W-1:0] rd_sym,
   output logic [ST_W-1:0]  rd_next,
   output logic [SYM_W-1:0] rd_wsym,
   output move_e            rd_move,
   output logic             rd_valid
);
   localparam int IDX_W   = ST_W + SYM_W;
   localparam int ENTRIES = 1 << IDX_W;

   typedef struct packed {
      logic             valid;
      logic [ST_W-1:0]  nxt;
      logic [SYM_W-1:0] wsym;
      move_e            mv;
   } entry_t;

   entry_t            ent_q [ENTRIES];
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   entry_t            wr_ent, rd_ent;

   assign wr_idx = {wr_state, wr_sym};
   assign rd_idx = {rd_state, rd_sym};

   always_comb begin
      wr_ent.valid = wr_valid;
      wr_ent.nxt   = wr_next;
      wr_ent.wsym  = wr_wsym;
      wr_ent.mv    = wr_move;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
      end else if (wr_en) begin
         ent_q[wr_idx] <= wr_ent;
      end
   end

   assign rd_ent   = ent_q[rd_idx];
   assign rd_next  = rd_ent.nxt;
   assign rd_wsym  = rd_ent.wsym;
   assign rd_move  = rd_ent.mv;
   assign rd_valid = rd_ent.valid;

   // R9: a write lands in the addressed entry by the next edge
   a_r9_table_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ent_q[$past(wr_idx)].valid == $past(wr_valid)) &&
                (ent_q[$past(wr_idx)].nxt == $past(wr_next)));
endmodule

// File: rtl/tm_tape.sv
module tm_tape #(
   parameter int LEN   = 64,
   parameter int SYM_W = 2,
   parameter int BLANK = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [$clog2(LEN)-1:0] wr_addr,
   input  logic [SYM_W-1:0]       wr_data,
   input  logic [$clog2(LEN)-1:0] scan_addr,
   output logic [SYM_W-1:0]       scan_data,
   input  logic [$clog2(LEN)-1:0] peek_addr,
   output logic [SYM_W-1:0]       peek_data
);
   localparam int AW = $clog2(LEN);

   logic [SYM_W-1:0] cells [LEN];

   for (genvar c = 0; c < LEN; c++) begin : g_cell
      logic [SYM_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            q <= SYM_W'(BLANK);
         else if (wr_en && wr_addr == AW'(c))   q <= wr_data;
      end
      assign cells[c] = q;
   end

   assign scan_data = cells[scan_addr];
   assign peek_data = cells[peek_addr];

   // R3: the write symbol is present in its cell after the edge
   a_r3_cell_written: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cells[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/tm_head.sv
module tm_head
   import tm_pkg::*;
#(
   parameter int LEN  = 64,
   parameter int INIT = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ld_en,
   input  logic [$clog2(LEN)-1:0] ld_pos,
   input  logic                   step_en,
   input  move_e                  move,
   output logic [$clog2(LEN)-1:0] pos,
   output logic                   off_end
);
   localparam int AW   = $clog2(LEN);
   localparam bit POW2 = (LEN == (1 << AW));

   logic [AW-1:0] pos_q, pos_nx;
   logic          at_lo, at_hi;

   assign at_lo = (pos_q == '0);

   if (POW2) begin : g_pow2
      assign at_hi = &pos_q;
   end else begin : g_cmp
      assign at_hi = (pos_q == AW'(LEN - 1));
   end

   always_comb begin
      off_end = 1'b0;
      pos_nx  = pos_q;
      case (move)
         MV_DEC: begin off_end = at_lo; pos_nx = pos_q - AW'(1); end
         MV_INC: begin off_end = at_hi; pos_nx = pos_q + AW'(1); end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pos_q <= AW'(INIT);
      else if (ld_en)               pos_q <= ld_pos;
      else if (step_en && !off_end) pos_q <= pos_nx;
   end

   assign pos = pos_q;

   // R3: a step moves the head by at most one cell
   a_r3_single_cell: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ld_en) |=> (pos_q == $past(pos_q)) ||
                              (pos_q == $past(pos_q) + AW'(1)) ||
                              (pos_q == $past(pos_q) - AW'(1)));
endmodule

// File: rtl/tm_engine.sv
module tm_engine
   import tm_pkg::*;
#(
   parameter int ST_W     = 4,
   parameter int SYM_W    = 2,
   parameter int TAPE_LEN = 64,
   parameter int HEAD_INIT = 32,
   parameter int CNT_W    = 16,
   parameter int START_ST = 0,
   parameter int HALT_ST  = 14,
   parameter int ERR_ST   = 15
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        tbl_we,
   input  logic [ST_W-1:0]             tbl_state,
   input  logic [SYM_W-1:0]            tbl_sym,
   input  logic [ST_W-1:0]             tbl_next,
   input  logic [SYM_W-1:0]            tbl_wsym,
   input  logic [1:0]                  tbl_move,
   input  logic                        tbl_valid,
   input  logic                        tape_we,
   input  logic [$clog2(TAPE_LEN)-1:0] tape_addr,
   input  logic [SYM_W-1:0]            tape_wdata,
   input  logic                        head_we,
   input  logic [$clog2(TAPE_LEN)-1:0] head_wdata,
   input  logic [$clog2(TAPE_LEN)-1:0] rd_addr,
   output logic [SYM_W-1:0]            rd_data,
   output logic                        running,
   output logic                        halted,
   output logic                        error,
   output logic [CNT_W-1:0]            step_count,
   output logic [ST_W-1:0]             cur_state,
   output logic [$clog2(TAPE_LEN)-1:0] head_pos
);
   localparam int AW = $clog2(TAPE_LEN);
   localparam logic [ST_W-1:0] ST_START = ST_W'(START_ST);
   localparam logic [ST_W-1:0] ST_HALT  = ST_W'(HALT_ST);
   localparam logic [ST_W-1:0] ST_ERR   = ST_W'(ERR_ST);

   // elaboration-time parameter checks
   if (HALT_ST == ERR_ST || START_ST == HALT_ST || START_ST == ERR_ST) begin : g_bad_codes
      $error("tm_engine: start, halt and error codes must differ");
   end
   if (ERR_ST >= (1 << ST_W) || HALT_ST >= (1 << ST_W)) begin : g_bad_width
      $error("tm_engine: reserved state codes exceed ST_W");
   end
   if (TAPE_LEN < 2 || HEAD_INIT >= TAPE_LEN) begin : g_bad_tape
      $error("tm_engine: tape length or initial head out of range");
   end

   logic             running_q;
   logic [ST_W-1:0]  state_q;
   logic [CNT_W-1:0] steps_q;
   logic [AW-1:0]    head_q;
   logic [SYM_W-1:0] scan_sym;
   logic [ST_W-1:0]  ent_next;
   logic [SYM_W-1:0] ent_wsym;
   move_e            ent_move;
   logic             ent_valid;
   logic             off_end;
   logic             apply_w, idle_w;
   logic             tape_wr_en;
   logic [AW-1:0]    tape_wr_addr;
   logic [SYM_W-1:0] tape_wr_data;

   assign idle_w  = !running_q;
   assign apply_w = running_q && ent_valid;

   tm_action_table #(.ST_W(ST_W), .SYM_W(SYM_W)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we && idle_w),
      .wr_state (tbl_state),
      .wr_sym   (tbl_sym),
      .wr_next  (tbl_next),
      .wr_wsym  (tbl_wsym),
      .wr_move  (move_e'(tbl_move)),
      .wr_valid (tbl_valid),
      .rd_state (state_q),
      .rd_sym   (scan_sym),
      .rd_next  (ent_next),
      .rd_wsym  (ent_wsym),
      .rd_move  (ent_move),
      .rd_valid (ent_valid)
   );

   // machine write has the port while running; preload only when idle
   assign tape_wr_en   = apply_w || (tape_we && idle_w);
   assign tape_wr_addr = apply_w ? head_q   : tape_addr;
   assign tape_wr_data = apply_w ? ent_wsym : tape_wdata;

   tm_tape #(.LEN(TAPE_LEN), .SYM_W(SYM_W), .BLANK(0)) u_tape (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (tape_wr_en),
      .wr_addr   (tape_wr_addr),
      .wr_data   (tape_wr_data),
      .scan_addr (head_q),
      .scan_data (scan_sym),
      .peek_addr (rd_addr),
      .peek_data (rd_data)
   );

   tm_head #(.LEN(TAPE_LEN), .INIT(HEAD_INIT)) u_head (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (head_we && idle_w),
      .ld_pos  (head_wdata),
      .step_en (apply_w),
      .move    (ent_move),
      .pos     (head_q),
      .off_end (off_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         state_q   <= ST_START;
         steps_q   <= '0;
      end else if (idle_w) begin
         if (start) begin
            running_q <= 1'b1;
            state_q   <= ST_START;
            steps_q   <= '0;
         end
      end else if (!ent_valid) begin
         state_q   <= ST_ERR;
         running_q <= 1'b0;
      end else begin
         if (~&steps_q) steps_q <= steps_q + CNT_W'(1);
         if (off_end) begin
            state_q   <= ST_ERR;
            running_q <= 1'b0;
         end else begin
            state_q <= ent_next;
            if (ent_next == ST_HALT || ent_next == ST_ERR) running_q <= 1'b0;
         end
      end
   end

   assign running    = running_q;
   assign halted     = (state_q == ST_HALT);
   assign error      = (state_q == ST_ERR);
   assign step_count = steps_q;
   assign cur_state  = state_q;
   assign head_pos   = head_q;

   // R4: the halt code is never held while running
   a_r4_halt_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT) |-> !running_q);

   // R5: an undefined pair leads to error with head and count untouched
   a_r5_undefined_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && !ent_valid) |=> (state_q == ST_ERR) && !running_q &&
                                    $stable(head_q) && $stable(steps_q));

   // R7: a move past either end stops in error with the head in place
   a_r7_edge_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && ent_valid && off_end) |=> (state_q == ST_ERR) && !running_q &&
                                              $stable(head_q));

   // R8: a full counter stays full until a new start
   a_r8_saturated: assert property (@(posedge clk) disable iff (!rst_n)
      ((&steps_q) && !(start && idle_w)) |=> (&steps_q));

   // R9: an idle engine without start or head load keeps its state
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_w && !start && !head_we) |=> $stable(state_q) && $stable(head_q) &&
                                         $stable(steps_q) && !running_q);
endmodule

// File: tb/test_tm_engine.sv
module test_tm_engine;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       tbl_we = 1'b0;
   logic [3:0] tbl_state = '0;
   logic [1:0] tbl_sym = '0;
   logic [3:0] tbl_next = '0;
   logic [1:0] tbl_wsym = '0;
   logic [1:0] tbl_move = '0;
   logic       tbl_valid = 1'b0;
   logic       tape_we = 1'b0;
   logic [5:0] tape_addr = '0;
   logic [1:0] tape_wdata = '0;
   logic       head_we = 1'b0;
   logic [5:0] head_wdata = '0;
   logic [5:0] rd_addr = '0;
   logic [1:0] rd_data;
   logic       running, halted, error;
   logic [15:0] step_count;
   logic [3:0] cur_state;
   logic [5:0] head_pos;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int sweep = 0;

   // behavioural reference model
   int m_tape [64];
   int m_next [64];
   int m_wsym [64];
   int m_move [64];
   bit m_valid [64];
   int m_state, m_head, m_steps;
   bit m_run;

   tm_engine i_tm_engine (
      .clk(clk), .rst_n(rst_n), .start(start),
      .tbl_we(tbl_we), .tbl_state(tbl_state), .tbl_sym(tbl_sym),
      .tbl_next(tbl_next), .tbl_wsym(tbl_wsym), .tbl_move(tbl_move),
      .tbl_valid(tbl_valid),
      .tape_we(tape_we), .tape_addr(tape_addr), .tape_wdata(tape_wdata),
      .head_we(head_we), .head_wdata(head_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .running(running), .halted(halted), .error(error),
      .step_count(step_count), .cur_state(cur_state), .head_pos(head_pos)
   );

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) begin
            m_tape[i] = 0; m_next[i] = 0; m_wsym[i] = 0; m_move[i] = 0; m_valid[i] = 0;
         end
         m_state = 0; m_head = 32; m_steps = 0; m_run = 0;
      end else if (!m_run) begin
         if (tbl_we) begin
            m_next[tbl_state*4 + tbl_sym]  = tbl_next;
            m_wsym[tbl_state*4 + tbl_sym]  = tbl_wsym;
            m_move[tbl_state*4 + tbl_sym]  = tbl_move;
            m_valid[tbl_state*4 + tbl_sym] = tbl_valid;
         end
         if (tape_we) m_tape[tape_addr] = tape_wdata;
         if (head_we) m_head = head_wdata;
         if (start) begin m_run = 1; m_state = 0; m_steps = 0; end
      end else begin
         int idx, nh;
         idx = m_state*4 + m_tape[m_head];
         if (!m_valid[idx]) begin
            m_state = 15; m_run = 0;
         end else begin
            m_tape[m_head] = m_wsym[idx];
            if (m_steps < 65535) m_steps++;
            nh = m_head + ((m_move[idx] == 1) ? -1 : (m_move[idx] == 2) ? 1 : 0);
            if (nh < 0 || nh > 63) begin
               m_state = 15; m_run = 0;
            end else begin
               m_head = nh; m_state = m_next[idx];
               if (m_state == 14 || m_state == 15) m_run = 0;
            end
         end
      end
   end

   task automatic chk(string rq, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic compare(string rq);
      chk(rq, "running", int'(running), int'(m_run));
      chk(rq, "cur_state", int'(cur_state), m_state);
      chk(rq, "head_pos", int'(head_pos), m_head);
      chk(rq, "step_count", int'(step_count), m_steps);
      chk(rq, "halted", int'(halted), int'(m_state == 14));
      chk(rq, "error", int'(error), int'(m_state == 15));
      rd_addr = 6'(sweep);
      sweep = (sweep + 7) % 64;
      #1;
      chk("R10", "rd_data", int'(rd_data), m_tape[rd_addr]);
   endtask

   task automatic tick(string rq);
      @(posedge clk);
      #(CLK_P/4);
      compare(rq);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick("R1");
      tick("R1");
      rst_n = 1'b1;
   endtask

   task automatic load(int st, int sy, int nx, int ws, int mv, bit vl);
      tbl_state = 4'(st); tbl_sym = 2'(sy); tbl_next = 4'(nx);
      tbl_wsym = 2'(ws); tbl_move = 2'(mv); tbl_valid = vl;
      tbl_we = 1'b1;
      tick("R9");
      tbl_we = 1'b0;
   endtask

   task automatic set_head(int p);
      head_wdata = 6'(p); head_we = 1'b1;
      tick("R9");
      head_we = 1'b0;
   endtask

   task automatic go();
      start = 1'b1;
      tick("R2");
      start = 1'b0;
   endtask

   task automatic run_idle(string rq, int cap);
      for (int k = 0; k < cap && running; k++) tick(rq);
   endtask

   task automatic peek(string rq, int a, int exp);
      rd_addr = 6'(a);
      #1;
      chk(rq, "tape cell", int'(rd_data), exp);
   endtask

   initial begin
      #(CLK_P*190000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      do_reset();
      tick("R1");
      chk("R1", "reset running", int'(running), 0);
      chk("R1", "reset state", int'(cur_state), 0);
      chk("R1", "reset head", int'(head_pos), 32);
      chk("R1", "reset count", int'(step_count), 0);
      for (int a = 0; a < 64; a += 9) peek("R1", a, 0);

      // R11 / R3 / R4: busy beaver on a blank tape
      load(0, 0, 1, 1, 1, 1);
      load(0, 1, 2, 1, 2, 1);
      load(1, 0, 0, 1, 2, 1);
      load(1, 1, 1, 1, 1, 1);
      load(2, 0, 1, 1, 2, 1);
      load(2, 1, 14, 1, 1, 1);
      go();
      run_idle("R3", 50);
      chk("R11", "beaver steps", int'(step_count), 13);
      chk("R11", "beaver head", int'(head_pos), 31);
      chk("R4", "beaver halted", int'(halted), 1);
      chk("R4", "beaver running", int'(running), 0);
      for (int a = 30; a <= 35; a++) peek("R11", a, 1);
      peek("R11", 29, 0);
      peek("R11", 36, 0);

      // R5: undefined entry after reset
      do_reset();
      go();
      tick("R5");
      chk("R5", "undefined error", int'(error), 1);
      chk("R5", "undefined count", int'(step_count), 0);
      chk("R5", "undefined head", int'(head_pos), 32);
      peek("R5", 32, 0);

      // R6: explicit error next state; R3 move code 3 and halt
      load(0, 0, 15, 3, 2, 1);
      go();
      tick("R6");
      chk("R6", "error via table", int'(error), 1);
      chk("R6", "head moved", int'(head_pos), 33);
      peek("R6", 32, 3);
      load(0, 0, 14, 2, 3, 1);
      go();
      tick("R3");
      chk("R3", "move code 3 stays", int'(head_pos), 33);
      chk("R4", "halt via code 14", int'(halted), 1);
      peek("R3", 33, 2);

      // R7: both tape ends
      do_reset();
      load(0, 0, 0, 3, 1, 1);
      set_head(0);
      go();
      tick("R7");
      chk("R7", "low end error", int'(error), 1);
      chk("R7", "low end head", int'(head_pos), 0);
      chk("R7", "low end count", int'(step_count), 1);
      peek("R7", 0, 3);
      load(0, 0, 0, 2, 2, 1);
      set_head(63);
      go();
      tick("R7");
      chk("R7", "high end error", int'(error), 1);
      chk("R7", "high end head", int'(head_pos), 63);
      peek("R7", 63, 2);

      // R9 / R2: loads and start ignored while running
      do_reset();
      load(0, 0, 0, 2, 2, 1);
      set_head(40);
      go();
      tick("R9");
      tape_addr = 6'd50; tape_wdata = 2'd1; tape_we = 1'b1;
      tbl_state = 4'd0; tbl_sym = 2'd0; tbl_valid = 1'b0; tbl_we = 1'b1;
      head_wdata = 6'd10; head_we = 1'b1; start = 1'b1;
      tick("R9");
      tick("R9");
      tape_we = 1'b0; tbl_we = 1'b0; head_we = 1'b0; start = 1'b0;
      run_idle("R9", 40);
      chk("R9", "ran to end", int'(error), 1);
      chk("R2", "no restart count", int'(step_count), 24);
      peek("R9", 50, 2);
      peek("R9", 10, 0);

      // R8: saturation
      do_reset();
      load(0, 0, 0, 0, 0, 1);
      go();
      for (int k = 0; k < 65540; k++) tick("R8");
      chk("R8", "saturated", int'(step_count), 65535);
      chk("R8", "still running", int'(running), 1);
      do_reset();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule